// File: doc/BRIEF.md
# Processor Power-Up Sequencer

This block takes a processor subsystem from a fully powered-down state to a running core. It uses a fixed ordering of steps. After a start pulse it latches a boot vector for the core. It then asserts every reset and turns on the oscillator clock branch. It polls that branch's clock-off status once per microsecond tick and gives up after a bounded number of polls. Next it raises the block head switch, bypasses the regulator and releases the memory clamps and retention controls. It then powers the memory banks one at a time, highest index first, and waits a settle time after each bank. Finally it removes the remaining clamps, releases core reset, enables the core clock and lets the core execute.

The clock branch, the memory macros and the core are outside the block. The block drives their control pins and reads back the clock-off status. The power-control bits are held in one internal 32-bit word with a fixed bit layout: standby 18, retention 19, IO clamp 20, word-line clamp 21, compiler-memory clamp 22, head switch 24, regulator bypass 25. Each power-control output is wired to its bit. The block finishes in one of two resting states, done or error. Both states are sticky until the next start.

Top module: `pwrseq_top`

## Requirements
- R1: After reset: core_rst=1, core_stop=1, bus_rst_en=0, xo_en=0, core_clk_en=0, hs_on=0, ldo_byp=0, all three clamps (qmc_clamp, wl_clamp, io_clamp)=1, l2_stby_n=0, slp_ret_n=0, mem_pwr all zero, boot_vec=0, done=0, err=0.
- R2: When start is sampled while the block is not sequencing, boot_vec takes boot_addr[ADDR_W-1:4] on that same edge. On the next edge core_rst, bus_rst_en and core_stop are all 1. All three stay held until the release steps of R8.
- R3: After the resets, xo_en is set. On each us_tick the block samples xo_clkoff. The first sampled 0 moves the sequence to the head switch. If the 200th consecutive sample is still 1, the sequence stops with err. The head switch stays off while the status is 1.
- R4: hs_on is set first. Then at least SETTLE_US ticks pass, and only after that is ldo_byp set.
- R5: After ldo_byp, qmc_clamp is cleared. Then l2_stby_n and slp_ret_n rise together on one edge. Both are set before any memory bank powers up.
- R6: Memory banks power up one per step, from bit N_BANKS-1 down to bit 0. No two bits change on the same edge, and at least SETTLE_US ticks separate two bank steps.
- R7: Only after bank 0 is on is wl_clamp cleared, and then io_clamp, on separate edges.
- R8: After the IO clamp release, core_rst falls, then core_clk_en rises, then core_stop falls, each on a later edge. done rises on the edge that clears core_stop.
- R9: On a poll timeout every power, clock, reset and bank output keeps its value. In particular core_rst stays 1 and hs_on stays 0.
- R10: A start pulse during a running sequence has no effect. boot_vec keeps its value and the sequence completes normally.
- R11: done and err are never 1 together. Each stays set until the next accepted start, which clears it on the edge that samples start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle, done or in error |
| boot_addr | input | ADDR_W | Byte address the core boots from |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| xo_clkoff | input | 1 | Oscillator branch clock-off status, 1 while the clock is off |
| boot_vec | output | ADDR_W-4 | Boot vector for the core, boot_addr shifted right by 4 |
| xo_en | output | 1 | Oscillator clock-branch enable |
| core_rst | output | 1 | Core reset |
| bus_rst_en | output | 1 | Bus reset enable |
| core_stop | output | 1 | Holds the core from executing |
| core_clk_en | output | 1 | Core clock enable |
| hs_on | output | 1 | Block head switch on |
| ldo_byp | output | 1 | Regulator bypass |
| qmc_clamp | output | 1 | Compiler-memory clamp |
| wl_clamp | output | 1 | Word-line clamp |
| io_clamp | output | 1 | IO clamp |
| l2_stby_n | output | 1 | L2 data standby, active low |
| slp_ret_n | output | 1 | Sleep retention, active low |
| mem_pwr | output | N_BANKS | Per-bank memory power switch |
| done | output | 1 | Sequence completed, sticky |
| err | output | 1 | Clock-ready timeout, sticky |

## Verification
boot_vec and the clearing of done and err are due one cycle after the edge that samples start. The resets are due the cycle after that, and xo_en the cycle after the resets. A poll result or a settle end shows one cycle after the edge that consumes the tick. The bench therefore reads single-step results at the falling edge that follows the edge in question, and it counts the ticks it drives to place the 199th and 200th poll exactly. For the long ordering it stamps, half a nanosecond after every rising edge, the cycle and tick count at which each output first reaches its target. It then compares stamps and tick differences, so no check relies on an absolute latency.

// File: rtl/pwrseq_pkg.sv
// Shared definitions for the power-up sequencer.
// Assumes: the power-control word is 32 bits wide and its field positions are fixed.
package pwrseq_pkg;

    localparam int CTL_W       = 32;
    localparam int BOOT_SHIFT  = 4;

    // power-control word field positions
    localparam int B_STBY_N    = 18;
    localparam int B_RET_N     = 19;
    localparam int B_CLAMP_IO  = 20;
    localparam int B_CLAMP_WL  = 21;
    localparam int B_CLAMP_QMC = 22;
    localparam int B_HS_ON     = 24;
    localparam int B_LDO_BYP   = 25;

    // power-off value: all clamps engaged, everything else off
    localparam logic [CTL_W-1:0] CTL_OFF =
        (CTL_W'(1) << B_CLAMP_IO) | (CTL_W'(1) << B_CLAMP_WL) | (CTL_W'(1) << B_CLAMP_QMC);

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_ARM,
        ST_XO_ON,
        ST_XO_POLL,
        ST_HS_ON,
        ST_HS_SETTLE,
        ST_LDO,
        ST_QMC,
        ST_RET,
        ST_BANK_ON,
        ST_BANK_SETTLE,
        ST_WL,
        ST_IO,
        ST_REL,
        ST_CLK,
        ST_GO,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/pwrseq_wait_cnt.sv
// Tick counter shared by the clock-ready poll and the settle waits.
// Counts us_tick pulses while a wait state is active and clears otherwise.
// Assumes: the controller leaves a wait state before the counter can wrap.
module pwrseq_wait_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    // count ticks inside a wait, restart at zero outside
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwrseq_bank_ctrl.sv
// Memory bank power switches, turned on one per step from the top index down.
// Assumes: load comes with an accepted start; set_en and dec never coincide with load.
module pwrseq_bank_ctrl #(
    parameter int N_BANKS = 20,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               set_en,
    input  logic               dec,
    output logic [N_BANKS-1:0] mem_pwr,
    output logic               last
);

    logic [IDX_W-1:0] idx;

    // bank pointer: starts at the highest bank, steps down after each settle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= IDX_W'(N_BANKS - 1);
        end else if (load) begin
            idx <= IDX_W'(N_BANKS - 1);
        end else if (dec) begin
            idx <= idx - IDX_W'(1);
        end
    end

    assign last = (idx == '0);

    // one switch flop per bank, set when the pointer selects it
    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_pwr[g] <= 1'b0;
            end else if (set_en && (idx == IDX_W'(g))) begin
                mem_pwr[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwrseq_fsm.sv
// Step controller of the sequencer: one output step per state, waits on us_tick.
// Assumes: wait_cnt counts ticks since the current wait state was entered.
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int POLL_MAX  = 200,
    parameter int SETTLE_US = 1,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             us_tick,
    input  logic             xo_clkoff,
    input  logic [CNT_W-1:0] wait_cnt,
    input  logic             bank_last,
    output seq_state_e       state,
    output logic             accept,
    output logic             wait_active,
    output logic             bank_set,
    output logic             bank_dec
);

    localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_MAX - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_US - 1);

    seq_state_e nxt;
    logic       resting;
    logic       settle_hit;

    assign resting     = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
    assign accept      = start && resting;
    assign settle_hit  = us_tick && (wait_cnt == SETTLE_LAST);
    assign wait_active = (state == ST_XO_POLL) || (state == ST_HS_SETTLE) ||
                         (state == ST_BANK_SETTLE);
    assign bank_set    = (state == ST_BANK_ON);
    assign bank_dec    = (state == ST_BANK_SETTLE) && settle_hit && !bank_last;

    // next step of the power-up order
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) nxt = ST_ARM;
            ST_ARM:        nxt = ST_XO_ON;
            ST_XO_ON:      nxt = ST_XO_POLL;
            ST_XO_POLL: begin
                if (us_tick) begin
                    if (!xo_clkoff) begin
                        nxt = ST_HS_ON;
                    end else if (wait_cnt == POLL_LAST) begin
                        nxt = ST_FAIL;
                    end
                end
            end
            ST_HS_ON:      nxt = ST_HS_SETTLE;
            ST_HS_SETTLE:  if (settle_hit) nxt = ST_LDO;
            ST_LDO:        nxt = ST_QMC;
            ST_QMC:        nxt = ST_RET;
            ST_RET:        nxt = ST_BANK_ON;
            ST_BANK_ON:    nxt = ST_BANK_SETTLE;
            ST_BANK_SETTLE: begin
                if (settle_hit) nxt = bank_last ? ST_WL : ST_BANK_ON;
            end
            ST_WL:         nxt = ST_IO;
            ST_IO:         nxt = ST_REL;
            ST_REL:        nxt = ST_CLK;
            ST_CLK:        nxt = ST_GO;
            ST_GO:         nxt = ST_DONE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/pwrseq_top.sv
// Processor power-up sequencer top: holds the power-control word, reset and
// clock controls and the boot vector, and applies each step the controller selects.
// Assumes: us_tick is a single-cycle pulse; xo_clkoff is synchronous to clk.
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int N_BANKS   = 20,
    parameter int POLL_MAX  = 200,
    parameter int SETTLE_US = 1,
    parameter int ADDR_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            boot_addr,
    input  logic                         us_tick,
    input  logic                         xo_clkoff,
    output logic [ADDR_W-BOOT_SHIFT-1:0] boot_vec,
    output logic                         xo_en,
    output logic                         core_rst,
    output logic                         bus_rst_en,
    output logic                         core_stop,
    output logic                         core_clk_en,
    output logic                         hs_on,
    output logic                         ldo_byp,
    output logic                         qmc_clamp,
    output logic                         wl_clamp,
    output logic                         io_clamp,
    output logic                         l2_stby_n,
    output logic                         slp_ret_n,
    output logic [N_BANKS-1:0]           mem_pwr,
    output logic                         done,
    output logic                         err
);

    localparam int CNT_LIM = (POLL_MAX > SETTLE_US) ? POLL_MAX : SETTLE_US;
    localparam int CNT_W   = $clog2(CNT_LIM + 1);
    localparam int IDX_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
    localparam int VEC_W   = ADDR_W - BOOT_SHIFT;

    seq_state_e       state;
    logic             accept;
    logic             wait_active;
    logic             bank_set;
    logic             bank_dec;
    logic             bank_last;
    logic [CNT_W-1:0] wait_cnt;
    logic [CTL_W-1:0] pwr_ctl;
    logic [VEC_W-1:0] vec_q;
    logic             rst_core_q, rst_bus_q, stop_q, xo_en_q, clk_en_q;
    logic             ctl_unused;
    logic             addr_unused;

    pwrseq_fsm #(
        .POLL_MAX (POLL_MAX),
        .SETTLE_US(SETTLE_US),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .us_tick    (us_tick),
        .xo_clkoff  (xo_clkoff),
        .wait_cnt   (wait_cnt),
        .bank_last  (bank_last),
        .state      (state),
        .accept     (accept),
        .wait_active(wait_active),
        .bank_set   (bank_set),
        .bank_dec   (bank_dec)
    );

    pwrseq_wait_cnt #(
        .CNT_W(CNT_W)
    ) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!wait_active),
        .tick (us_tick),
        .cnt  (wait_cnt)
    );

    pwrseq_bank_ctrl #(
        .N_BANKS(N_BANKS),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .set_en (bank_set),
        .dec    (bank_dec),
        .mem_pwr(mem_pwr),
        .last   (bank_last)
    );

    // boot vector captured on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (accept) begin
            vec_q <= boot_addr[ADDR_W-1:BOOT_SHIFT];
        end
    end

    // power-control word: head switch, bypass, clamps and retention per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_ctl <= CTL_OFF;
        end else begin
            case (state)
                ST_HS_ON: pwr_ctl[B_HS_ON]     <= 1'b1;
                ST_LDO:   pwr_ctl[B_LDO_BYP]   <= 1'b1;
                ST_QMC:   pwr_ctl[B_CLAMP_QMC] <= 1'b0;
                ST_RET: begin
                    pwr_ctl[B_STBY_N] <= 1'b1;
                    pwr_ctl[B_RET_N]  <= 1'b1;
                end
                ST_WL:    pwr_ctl[B_CLAMP_WL]  <= 1'b0;
                ST_IO:    pwr_ctl[B_CLAMP_IO]  <= 1'b0;
                default: ;
            endcase
        end
    end

    // reset, stop and clock controls per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_core_q <= 1'b1;
            rst_bus_q  <= 1'b0;
            stop_q     <= 1'b1;
            xo_en_q    <= 1'b0;
            clk_en_q   <= 1'b0;
        end else begin
            case (state)
                ST_ARM: begin
                    rst_core_q <= 1'b1;
                    rst_bus_q  <= 1'b1;
                    stop_q     <= 1'b1;
                end
                ST_XO_ON: xo_en_q    <= 1'b1;
                ST_REL:   rst_core_q <= 1'b0;
                ST_CLK:   clk_en_q   <= 1'b1;
                ST_GO:    stop_q     <= 1'b0;
                default: ;
            endcase
        end
    end

    assign ctl_unused  = ^pwr_ctl;
    assign addr_unused = ^boot_addr[BOOT_SHIFT-1:0];

    assign boot_vec    = vec_q;
    assign xo_en       = xo_en_q;
    assign core_rst    = rst_core_q;
    assign bus_rst_en  = rst_bus_q;
    assign core_stop   = stop_q;
    assign core_clk_en = clk_en_q;
    assign hs_on       = pwr_ctl[B_HS_ON];
    assign ldo_byp     = pwr_ctl[B_LDO_BYP];
    assign qmc_clamp   = pwr_ctl[B_CLAMP_QMC];
    assign wl_clamp    = pwr_ctl[B_CLAMP_WL];
    assign io_clamp    = pwr_ctl[B_CLAMP_IO];
    assign l2_stby_n   = pwr_ctl[B_STBY_N];
    assign slp_ret_n   = pwr_ctl[B_RET_N];
    assign done        = (state == ST_DONE);
    assign err         = (state == ST_FAIL);

endmodule

// File: rtl/pwrseq_chk.sv
// Ordering and hold properties of the power-up sequencer, bound to its top.
// Assumes: only the top's ports are observed.
module pwrseq_chk #(
    parameter int N_BANKS = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               xo_en,
    input logic               core_rst,
    input logic               core_stop,
    input logic               core_clk_en,
    input logic               hs_on,
    input logic               ldo_byp,
    input logic               qmc_clamp,
    input logic               wl_clamp,
    input logic               io_clamp,
    input logic               l2_stby_n,
    input logic               slp_ret_n,
    input logic [N_BANKS-1:0] mem_pwr,
    input logic               done,
    input logic               err
);

    // R4
    ldo_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo_byp) |-> hs_on);

    // R5
    bank_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pwr != $past(mem_pwr)) |-> (l2_stby_n && slp_ret_n && !qmc_clamp));

    // R6
    one_bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_pwr ^ $past(mem_pwr)) <= 1);

    // R7
    io_after_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_clamp) |-> ((&mem_pwr) && !wl_clamp));

    // R8
    clk_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> !core_rst);

    // R8
    run_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stop) |-> (core_clk_en && !core_rst && done));

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> ($stable(hs_on) && $stable(ldo_byp) && $stable(qmc_clamp) &&
                             $stable(wl_clamp) && $stable(io_clamp) && $stable(mem_pwr) &&
                             $stable(xo_en) && core_rst && !core_clk_en));

    // R11
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

bind pwrseq_top pwrseq_chk #(.N_BANKS(N_BANKS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .xo_en      (xo_en),
    .core_rst   (core_rst),
    .core_stop  (core_stop),
    .core_clk_en(core_clk_en),
    .hs_on      (hs_on),
    .ldo_byp    (ldo_byp),
    .qmc_clamp  (qmc_clamp),
    .wl_clamp   (wl_clamp),
    .io_clamp   (io_clamp),
    .l2_stby_n  (l2_stby_n),
    .slp_ret_n  (slp_ret_n),
    .mem_pwr    (mem_pwr),
    .done       (done),
    .err        (err)
);

// File: tb/test_pwrseq_top.sv
`timescale 1ns/1ps
// Directed bench for the power-up sequencer: one task per scenario.
module test_pwrseq_top;

    localparam int N_BANKS   = 20;
    localparam int POLL_MAX  = 200;
    localparam int SETTLE_US = 1;
    localparam int ADDR_W    = 32;
    localparam int TICK_DIV  = 8;

    localparam int EV_BUS = 0, EV_XO = 1, EV_HS = 2, EV_LDO = 3, EV_QMC = 4, EV_STBY = 5,
                   EV_RET = 6, EV_WL = 7, EV_IO = 8, EV_REL = 9, EV_CLK = 10, EV_RUN = 11,
                   EV_DONE = 12, NEV = 13;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                start;
    logic [ADDR_W-1:0]   boot_addr;
    logic                us_tick;
    logic                xo_clkoff;
    logic [ADDR_W-5:0]   boot_vec;
    logic                xo_en, core_rst, bus_rst_en, core_stop, core_clk_en;
    logic                hs_on, ldo_byp, qmc_clamp, wl_clamp, io_clamp, l2_stby_n, slp_ret_n;
    logic [N_BANKS-1:0]  mem_pwr;
    logic                done, err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int cyc = 0;
    int ticks = 0;
    int st[NEV];
    int tk[NEV];
    int st_bk[N_BANKS];
    int tk_bk[N_BANKS];
    bit multi = 0;
    logic [N_BANKS-1:0] mem_prev = '0;

    always #2 clk = ~clk;

    pwrseq_top #(
        .N_BANKS(N_BANKS), .POLL_MAX(POLL_MAX), .SETTLE_US(SETTLE_US), .ADDR_W(ADDR_W)
    ) i_pwrseq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .boot_addr(boot_addr), .us_tick(us_tick),
        .xo_clkoff(xo_clkoff), .boot_vec(boot_vec), .xo_en(xo_en), .core_rst(core_rst),
        .bus_rst_en(bus_rst_en), .core_stop(core_stop), .core_clk_en(core_clk_en),
        .hs_on(hs_on), .ldo_byp(ldo_byp), .qmc_clamp(qmc_clamp), .wl_clamp(wl_clamp),
        .io_clamp(io_clamp), .l2_stby_n(l2_stby_n), .slp_ret_n(slp_ret_n),
        .mem_pwr(mem_pwr), .done(done), .err(err)
    );

    // microsecond tick: one-cycle pulse every TICK_DIV cycles, driven after the edge
    initial begin
        us_tick = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk);
            #1 us_tick = 1'b1;
            @(posedge clk);
            #1 us_tick = 1'b0;
        end
    end

    // stamp the first cycle each output reaches its target value
    always begin
        @(posedge clk);
        #0.5;
        cyc++;
        if (us_tick) ticks++;
        if ($countones(mem_pwr ^ mem_prev) > 1) multi = 1;
        mem_prev = mem_pwr;
        stamp(EV_BUS,  bus_rst_en);
        stamp(EV_XO,   xo_en);
        stamp(EV_HS,   hs_on);
        stamp(EV_LDO,  ldo_byp);
        stamp(EV_QMC,  !qmc_clamp);
        stamp(EV_STBY, l2_stby_n);
        stamp(EV_RET,  slp_ret_n);
        stamp(EV_WL,   !wl_clamp);
        stamp(EV_IO,   !io_clamp);
        stamp(EV_REL,  !core_rst);
        stamp(EV_CLK,  core_clk_en);
        stamp(EV_RUN,  !core_stop);
        stamp(EV_DONE, done);
        for (int i = 0; i < N_BANKS; i++) begin
            if (mem_pwr[i] && st_bk[i] < 0) begin
                st_bk[i] = cyc;
                tk_bk[i] = ticks;
            end
        end
    end

    function automatic void stamp(input int ev, input logic hit);
        if (hit && st[ev] < 0) begin
            st[ev] = cyc;
            tk[ev] = ticks;
        end
    endfunction

    task automatic clear_stamps();
        for (int e = 0; e < NEV; e++) begin
            st[e] = -1;
            tk[e] = -1;
        end
        for (int i = 0; i < N_BANKS; i++) begin
            st_bk[i] = -1;
            tk_bk[i] = -1;
        end
        multi = 0;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_true(input string req, input string what, input bit cond);
        chk(req, what, longint'(cond), 1);
    endtask

    task automatic pulse_start(input logic [ADDR_W-1:0] addr);
        @(negedge clk);
        start     = 1'b1;
        boot_addr = addr;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        boot_addr = '0;
        xo_clkoff = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: power-off values after reset
    task automatic t_reset_state();
        do_reset();
        chk("R1", "core_rst", core_rst, 1);
        chk("R1", "core_stop", core_stop, 1);
        chk("R1", "bus_rst_en", bus_rst_en, 0);
        chk("R1", "xo_en", xo_en, 0);
        chk("R1", "core_clk_en", core_clk_en, 0);
        chk("R1", "hs_on/ldo_byp", {hs_on, ldo_byp}, 0);
        chk("R1", "clamps", {qmc_clamp, wl_clamp, io_clamp}, 3'b111);
        chk("R1", "retention", {l2_stby_n, slp_ret_n}, 0);
        chk("R1", "mem_pwr", mem_pwr, 0);
        chk("R1", "boot_vec", boot_vec, 0);
        chk("R1", "done/err", {done, err}, 0);
    endtask

    // full run; ready_after = polls that still see the clock off; fresh = starting from power-off
    task automatic t_run(input logic [ADDR_W-1:0] addr, input int ready_after,
                         input bit poke, input bit fresh);
        int n;
        clear_stamps();
        xo_clkoff = (ready_after != 0);
        pulse_start(addr);
        chk("R2", "boot_vec after start", boot_vec, longint'(addr >> 4));
        chk("R11", "done/err cleared by start", {done, err}, 0);
        @(negedge clk);
        chk("R2", "resets asserted", {core_rst, bus_rst_en, core_stop}, 3'b111);
        while (!xo_en) @(negedge clk);
        n = 0;
        while (ready_after != 0 && n < ready_after) begin
            if (us_tick) n++;
            @(negedge clk);
        end
        if (ready_after != 0) begin
            chk("R3", "head switch off while clock off", hs_on, 0);
            chk("R3", "no error before last poll", err, 0);
            xo_clkoff = 1'b0;
        end
        if (poke) begin
            while (!hs_on) @(negedge clk);
            pulse_start(addr ^ 32'hFFF0_0000);
            chk("R10", "boot_vec kept on busy start", boot_vec, longint'(addr >> 4));
            chk("R10", "busy start leaves flags", {done, err}, 0);
        end
        while (!done && !err) @(negedge clk);
        chk("R3", "completed without error", err, 0);
        chk("R10", "boot_vec at end", boot_vec, longint'(addr >> 4));
        if (fresh) chk_true("R2", "resets before clock branch", st[EV_BUS] < st[EV_XO]);
        chk_true("R3", "clock branch before head switch", st[EV_XO] < st[EV_HS]);
        chk_true("R4", "head switch before bypass", st[EV_HS] < st[EV_LDO]);
        chk_true("R4", "settle ticks before bypass", tk[EV_LDO] - tk[EV_HS] >= SETTLE_US);
        chk_true("R5", "bypass before qmc release", st[EV_LDO] < st[EV_QMC]);
        chk_true("R5", "qmc release before retention", st[EV_QMC] < st[EV_STBY]);
        chk("R5", "standby and retention together", st[EV_STBY], st[EV_RET]);
        chk_true("R5", "retention before first bank", st[EV_RET] < st_bk[N_BANKS-1]);
        for (int i = N_BANKS - 2; i >= 0; i--) begin
            chk_true("R6", $sformatf("bank %0d after bank %0d", i, i + 1), st_bk[i] > st_bk[i+1]);
            chk_true("R6", $sformatf("settle before bank %0d", i), tk_bk[i] - tk_bk[i+1] >= SETTLE_US);
        end
        chk("R6", "single bank per step", multi, 0);
        chk("R6", "all banks on", mem_pwr, {N_BANKS{1'b1}});
        chk_true("R7", "word-line after bank 0", st_bk[0] < st[EV_WL]);
        chk_true("R7", "io after word-line", st[EV_WL] < st[EV_IO]);
        chk_true("R8", "core reset release after io", st[EV_IO] < st[EV_REL]);
        chk_true("R8", "clock after reset release", st[EV_REL] < st[EV_CLK]);
        chk_true("R8", "run after clock", st[EV_CLK] < st[EV_RUN]);
        chk("R8", "done with run", st[EV_DONE], st[EV_RUN]);
        chk("R2", "bus reset still held", bus_rst_en, 1);
        repeat (20) @(negedge clk);
        chk("R11", "done sticky", {done, err}, 2'b10);
        chk("R8", "core running", {core_rst, core_clk_en, core_stop}, 3'b010);
    endtask

    // R3/R9: clock never becomes ready
    task automatic t_timeout();
        int n;
        xo_clkoff = 1'b1;
        pulse_start(32'h0001_2340);
        chk("R2", "boot_vec after start", boot_vec, 32'h1234);
        @(negedge clk);
        chk("R2", "resets asserted", {core_rst, bus_rst_en, core_stop}, 3'b111);
        while (!xo_en) @(negedge clk);
        n = 0;
        while (n < POLL_MAX) begin
            if (us_tick) begin
                n++;
                if (n == POLL_MAX - 1) begin
                    @(negedge clk);
                    chk("R3", "no error after 199 polls", err, 0);
                    continue;
                end
            end
            @(negedge clk);
        end
        chk("R3", "error after 200 polls", err, 1);
        chk("R11", "done low on error", done, 0);
        chk("R9", "core held in reset", {core_rst, core_stop, core_clk_en}, 3'b110);
        chk("R9", "head switch and bypass off", {hs_on, ldo_byp}, 0);
        chk("R9", "clamps held", {qmc_clamp, wl_clamp, io_clamp}, 3'b111);
        chk("R9", "banks off", mem_pwr, 0);
        chk("R9", "xo_en held", xo_en, 1);
        repeat (3 * TICK_DIV) @(negedge clk);
        chk("R11", "error sticky", err, 1);
        chk("R9", "outputs still held", {hs_on, ldo_byp, core_rst, io_clamp}, 4'b0011);
        chk("R9", "banks still off", mem_pwr, 0);
    endtask

    // R11: a start from the done state clears done on the sampling edge
    task automatic t_rerun(input logic [ADDR_W-1:0] addr);
        xo_clkoff = 1'b0;
        pulse_start(addr);
        chk("R11", "done cleared by restart", {done, err}, 0);
        chk("R2", "boot_vec reloaded", boot_vec, longint'(addr >> 4));
        while (!done && !err) @(negedge clk);
        chk("R11", "rerun ends done", {done, err}, 2'b10);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        clear_stamps();
        t_reset_state();
        t_run(32'h8000_0A50, 0, 1'b1, 1'b1);
        do_reset();
        t_timeout();
        t_run(32'h0040_0000, POLL_MAX - 1, 1'b0, 1'b0);
        t_rerun(32'h1234_5670);
        finish_up();
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule